// File: doc/BRIEF.md
# Multiplexed Digit Scanner

This block shares one 4-bit BCD bus among the five decades of a decimal counter. A position register walks a single active line across a five-bit digit-select vector. The bus carries the decade value for the position that line marks. The register moves one step for each rising edge seen on a dedicated scan clock input. That input is sampled in the system clock domain, so the scan rate is independent of the counting rate.

The scan walks from the most significant decade (ten-thousands) down to units and then wraps back. A level-sensitive scan reset parks the walk on ten-thousands. When the first decade is inhibited, a skip input shortens the walk to four positions by leaving units out. Two separate enables gate the data bus and the select vector. A disabled output drives zero and drops its own valid flag, which stands in for a high-impedance pin. For the units position the bus shows the counter's mode-adjusted display value, which the counter supplies on its own port.

Top module: `digit_scanner`

## Requirements
- R1: While `rst_n` is low at a clock edge, the position goes to ten-thousands, so `sel_out` reads 5'b10000 once outputs are enabled.
- R2: `sel_out` bit i marks position i: bit 0 units, bit 1 tens, bit 2 hundreds, bit 3 thousands, bit 4 ten-thousands. It has exactly one bit set while `oe_sel` is high.
- R3: `bcd_out` shows the digit of the selected position. Tens through ten-thousands come from `upper_digits` nibble (i-1), with tens in bits 3:0. Units comes from `units_disp`.
- R4: The position advances once in the clock cycle in which `scan_clk` is sampled high after being sampled low. Holding `scan_clk` high or low causes no further step. After `rst_n`, a low sample is needed before the first step.
- R5: With `skip_units` low, the order is ten-thousands, thousands, hundreds, tens, units, then back to ten-thousands.
- R6: With `skip_units` high, a step from tens goes to ten-thousands, so units is never selected. A step taken while units is selected also goes to ten-thousands.
- R7: While `scan_rst` is high at a clock edge, the position goes to ten-thousands. This takes priority over a scan edge in the same cycle.
- R8: With `oe_sel` low, `sel_out` is zero and `sel_valid` is low. The position is unaffected.
- R9: With `oe_data` low, `bcd_out` is zero and `bcd_valid` is low. This happens independently of `oe_sel`, and the position is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_clk | input | 1 | Scan clock; a sampled rising edge advances the position |
| scan_rst | input | 1 | Level scan reset to ten-thousands |
| skip_units | input | 1 | Shortens the walk to four positions |
| oe_data | input | 1 | Enable for the BCD bus |
| oe_sel | input | 1 | Enable for the select vector |
| units_disp | input | 4 | Mode-adjusted units display value |
| upper_digits | input | 16 | Tens to ten-thousands digits, 4 bits each, tens lowest |
| bcd_out | output | 4 | Selected digit, zero when disabled |
| bcd_valid | output | 1 | High when the BCD bus is enabled |
| sel_out | output | 5 | One-hot digit select, zero when disabled |
| sel_valid | output | 1 | High when the select vector is enabled |

## Verification
The bench holds `scan_clk` high for several cycles. A design that detects levels instead of edges would then race through the positions. It raises the skip input while units is selected, and a design that only handles the tens wrap would be left stuck at units or walk onto an invalid empty position. It asserts scan reset together with a scan edge, and a design with the priorities reversed would step away from ten-thousands. It also drops each enable in turn and re-enables it later. This exposes gating that corrupts the position, or a units lane that shows the wrong source.

// File: rtl/scan_pkg.sv
// Shared constants and helpers for the digit scanner.
// Assumes decades are ordered units first (index 0).
package scan_pkg;
    localparam int DEF_DIGITS  = 5;
    localparam int DEF_DIGIT_W = 4;

    // Returns the one-hot code of the most significant position.
    function automatic logic [DEF_DIGITS-1:0] top_code();
        logic [DEF_DIGITS-1:0] c;
        c = '0;
        c[DEF_DIGITS-1] = 1'b1;
        return c;
    endfunction
endpackage

// File: rtl/scan_edge.sv
// Rising-edge detector for the scan clock, sampled in the system clock domain.
// Assumes scan_clk is already synchronous to clk; the sample register resets
// high so a level held across reset is not taken as an edge.
module scan_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic scan_clk,
    output logic step
);
    logic prev_q;

    // Remember the previous sample of the scan clock.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= scan_clk;
    end

    // One-cycle pulse on a low-to-high change.
    always_comb step = scan_clk & ~prev_q;
endmodule

// File: rtl/scan_pos.sv
// One-hot position register for the scanner, walking from the top position
// down to position 0 and wrapping; skip leaves position 0 out.
// Assumes step is a single-cycle pulse.
module scan_pos #(
    parameter int NUM_DIGITS = scan_pkg::DEF_DIGITS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step,
    input  logic                  scan_rst,
    input  logic                  skip,
    output logic [NUM_DIGITS-1:0] pos
);
    localparam int TOP = NUM_DIGITS - 1;
    localparam logic [NUM_DIGITS-1:0] TOP_CODE = {1'b1, {(NUM_DIGITS-1){1'b0}}};

    logic [NUM_DIGITS-1:0] pos_q;
    logic [NUM_DIGITS-1:0] nxt;

    // Next position for each one-hot bit when a step is taken.
    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_next
        if (i == TOP) begin : g_top
            always_comb nxt[i] = pos_q[0] | (skip & pos_q[1]);
        end else if (i == 0) begin : g_unit
            always_comb nxt[i] = pos_q[1] & ~skip;
        end else begin : g_mid
            always_comb nxt[i] = pos_q[i+1];
        end
    end

    // Position register: reset and scan reset park on the top position.
    always_ff @(posedge clk) begin
        if (!rst_n)        pos_q <= TOP_CODE;
        else if (scan_rst) pos_q <= TOP_CODE;
        else if (step)     pos_q <= nxt;
    end

    always_comb pos = pos_q;

    AST_POS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(pos_q)); // R2
    AST_RESET_TOP: assert property (@(posedge clk)
        !rst_n |=> pos_q[TOP]); // R1
    AST_SCAN_RST_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        scan_rst |=> pos_q[TOP]); // R7
    AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !scan_rst) |=> $stable(pos_q)); // R4
    AST_SKIP_NO_UNITS: assert property (@(posedge clk) disable iff (!rst_n)
        (skip && !pos_q[0]) |=> !pos_q[0]); // R6
endmodule

// File: rtl/scan_mux.sv
// AND-OR selector picking the digit marked by a one-hot position.
// Assumes sel is one-hot; position 0 uses the display-adjusted units value.
module scan_mux #(
    parameter int NUM_DIGITS = scan_pkg::DEF_DIGITS,
    parameter int DIGIT_W    = scan_pkg::DEF_DIGIT_W
) (
    input  logic [NUM_DIGITS-1:0]              sel,
    input  logic [DIGIT_W-1:0]                 units_disp,
    input  logic [(NUM_DIGITS-1)*DIGIT_W-1:0]  upper_digits,
    output logic [DIGIT_W-1:0]                 digit
);
    logic [DIGIT_W-1:0] lane [NUM_DIGITS];

    // Lay out each position's digit source.
    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_lane
        if (i == 0) begin : g_units
            always_comb lane[i] = units_disp;
        end else begin : g_upper
            always_comb lane[i] = upper_digits[(i-1)*DIGIT_W +: DIGIT_W];
        end
    end

    // Merge the lanes under the one-hot select.
    always_comb begin
        digit = '0;
        for (int i = 0; i < NUM_DIGITS; i++)
            digit = digit | ({DIGIT_W{sel[i]}} & lane[i]);
    end
endmodule

// File: rtl/scan_gate.sv
// Output gate standing in for a three-state driver: zero data and a low
// valid flag when disabled.
module scan_gate #(
    parameter int W = 4
) (
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         valid
);
    // Pass or block the value.
    always_comb begin
        dout  = en ? din : '0;
        valid = en;
    end
endmodule

// File: rtl/digit_scanner.sv
// Digit scanner top: sampled scan edge, one-hot position walk, digit
// selection and independent gating of the data bus and select vector.
// Assumes all inputs are synchronous to clk.
module digit_scanner #(
    parameter int NUM_DIGITS = scan_pkg::DEF_DIGITS,
    parameter int DIGIT_W    = scan_pkg::DEF_DIGIT_W
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                scan_clk,
    input  logic                                scan_rst,
    input  logic                                skip_units,
    input  logic                                oe_data,
    input  logic                                oe_sel,
    input  logic [DIGIT_W-1:0]                  units_disp,
    input  logic [(NUM_DIGITS-1)*DIGIT_W-1:0]   upper_digits,
    output logic [DIGIT_W-1:0]                  bcd_out,
    output logic                                bcd_valid,
    output logic [NUM_DIGITS-1:0]               sel_out,
    output logic                                sel_valid
);
    logic                  step;
    logic [NUM_DIGITS-1:0] pos;
    logic [DIGIT_W-1:0]    digit;

    scan_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .scan_clk (scan_clk),
        .step     (step)
    );

    scan_pos #(.NUM_DIGITS(NUM_DIGITS)) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .scan_rst (scan_rst),
        .skip     (skip_units),
        .pos      (pos)
    );

    scan_mux #(.NUM_DIGITS(NUM_DIGITS), .DIGIT_W(DIGIT_W)) u_mux (
        .sel          (pos),
        .units_disp   (units_disp),
        .upper_digits (upper_digits),
        .digit        (digit)
    );

    scan_gate #(.W(DIGIT_W)) u_gate_bcd (
        .en    (oe_data),
        .din   (digit),
        .dout  (bcd_out),
        .valid (bcd_valid)
    );

    scan_gate #(.W(NUM_DIGITS)) u_gate_sel (
        .en    (oe_sel),
        .din   (pos),
        .dout  (sel_out),
        .valid (sel_valid)
    );

    AST_SEL_ONEHOT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> $onehot(sel_out)); // R2
    AST_SEL_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid |-> (sel_out == '0)); // R8
endmodule

// File: tb/digit_scanner_tb.sv
module digit_scanner_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scan_clk = 1'b0;
    logic        scan_rst = 1'b0;
    logic        skip_units = 1'b0;
    logic        oe_data = 1'b1;
    logic        oe_sel = 1'b1;
    logic [3:0]  units_disp = 4'd0;
    logic [15:0] upper_digits = 16'h0000;
    logic [3:0]  bcd_out;
    logic        bcd_valid;
    logic [4:0]  sel_out;
    logic        sel_valid;

    int total = 0;
    int bad = 0;
    int exp_pos = 4;
    logic prev_scan = 1'b1;
    bit done = 0;

    always #10 clk = ~clk;

    digit_scanner u_dut (
        .clk(clk), .rst_n(rst_n), .scan_clk(scan_clk), .scan_rst(scan_rst),
        .skip_units(skip_units), .oe_data(oe_data), .oe_sel(oe_sel),
        .units_disp(units_disp), .upper_digits(upper_digits),
        .bcd_out(bcd_out), .bcd_valid(bcd_valid),
        .sel_out(sel_out), .sel_valid(sel_valid)
    );

    // Next position from the requirements (R5, R6).
    function automatic int next_pos(int p, logic skip);
        if (p == 0) return 4;
        if (p == 1 && skip) return 4;
        return p - 1;
    endfunction

    function automatic logic [3:0] digit_of(int p);
        if (p == 0) return units_disp;
        return upper_digits[(p-1)*4 +: 4];
    endfunction

    // One clock: update the model at the edge, then sample at the falling edge.
    task automatic tick();
        @(posedge clk);
        if (!rst_n) begin
            exp_pos = 4; prev_scan = 1'b1;
        end else begin
            if (scan_rst) exp_pos = 4;
            else if (scan_clk && !prev_scan) exp_pos = next_pos(exp_pos, skip_units);
            prev_scan = scan_clk;
        end
        @(negedge clk);
    endtask

    task automatic check(string tag_s, string tag_b);
        logic [4:0] es;
        logic [3:0] eb;
        es = oe_sel ? 5'(1 << exp_pos) : 5'd0;
        eb = oe_data ? digit_of(exp_pos) : 4'd0;
        total++;
        if (sel_out !== es || sel_valid !== oe_sel) begin
            bad++;
            $display("FAIL %s sel: actual=%b/%b expected=%b/%b", tag_s, sel_out, sel_valid, es, oe_sel);
        end
        total++;
        if (bcd_out !== eb || bcd_valid !== oe_data) begin
            bad++;
            $display("FAIL %s bcd: actual=%h/%b expected=%h/%b", tag_b, bcd_out, bcd_valid, eb, oe_data);
        end
    endtask

    task automatic pulse(string tag);
        scan_clk = 1'b1; tick(); check(tag, "R3");
        scan_clk = 1'b0; tick(); check(tag, "R3");
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        units_disp = 4'd5; upper_digits = 16'h9372;
        tick(); tick();
        check("R1", "R3");                       // R1 reset state
        rst_n = 1'b1; tick(); check("R1", "R3");
        // R5: full walk with units included
        for (int i = 0; i < 5; i++) pulse("R5");
        // R4: held high gives one step only
        scan_clk = 1'b1;
        for (int i = 0; i < 4; i++) begin tick(); check("R4", "R3"); end
        scan_clk = 1'b0; tick(); check("R4", "R3");
        // R6: skip walk never shows units
        skip_units = 1'b1;
        for (int i = 0; i < 6; i++) pulse("R6");
        // R6: skip raised while units selected
        skip_units = 1'b0;
        while (exp_pos != 0) pulse("R5");
        skip_units = 1'b1; pulse("R6");
        skip_units = 1'b0;
        // R7: scan reset wins over a simultaneous edge
        pulse("R5"); pulse("R5");
        scan_rst = 1'b1; scan_clk = 1'b1; tick(); check("R7", "R3");
        scan_rst = 1'b0; scan_clk = 1'b0; tick(); check("R7", "R3");
        // R8 / R9: enables gate independently and keep the position
        oe_sel = 1'b0; pulse("R8"); oe_sel = 1'b1; tick(); check("R8", "R3");
        oe_data = 1'b0; pulse("R5"); check("R5", "R9"); oe_data = 1'b1; tick(); check("R2", "R9");
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            scan_clk     = 1'($urandom_range(0, 1));
            scan_rst     = ($urandom_range(0, 29) == 0);
            skip_units   = ($urandom_range(0, 3) == 0);
            oe_data      = ($urandom_range(0, 5) != 0);
            oe_sel       = ($urandom_range(0, 5) != 0);
            units_disp   = 4'($urandom_range(0, 9));
            upper_digits = 16'($urandom);
            rst_n        = ($urandom_range(0, 199) != 0);
            tick();
            check("R2/R5/R6/R8", "R3/R9");
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule